// File: doc/BRIEF.md
# Three-Level IO Address Walker

This block turns the page number of a device IO virtual address into a physical address. It reads three levels of 64-bit translation entries from memory: region, then segment, then page. A walk starts from a table origin and a protection flag that come with the request. One entry is fetched per level, at the current table origin plus eight times that level's index. Each entry is checked in turn. The walk then either moves on to the next table or ends with a result. The result carries the translated address, the frame size, the access rights and an error class.

Walk requests, memory reads and results all use valid/ready handshakes. A request is taken only when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is high only while no walk is running. A read request holds `mem_valid` and `mem_addr` steady until `mem_ready` is seen. The memory returns exactly one `rsp_valid` beat for each accepted read; this channel cannot be back-pressured. A result holds steady on the `res_*` pins until `res_ready` is seen.

Top module: `iova_walker`

## Requirements
- R1: The walk visits the region level, then the segment level, then the page level. Each fetch address is origin + 8*index. The region index is `req_vpn[29:19]` (IO address bits 41:31), the segment index is `req_vpn[18:8]` (bits 30:20) and the page index is `req_vpn[7:0]` (bits 19:12). The next origin is the region entry with bits 13:0 cleared, or the segment entry with bits 10:0 cleared.
- R2: Permission codes are 0 none, 1 read-only and 3 read-write. A walk starts at read-write, or at read-only when `req_prot` is set.
- R3: A fetched entry equal to zero ends the walk with error code 1 and permission none.
- R4: An entry with its valid bit clear ends the walk with permission none, error code 0 and address 0. The valid bit is bit 4 in region and segment entries and bit 10 in page entries.
- R5: A region entry ends the walk with error code 2 if its length field (bits 1:0) is not 3 or its offset field (bits 7:6) is non-zero.
- R6: Error code 3 ends the walk in two cases. The first is a type field (bits 3:2) that does not match the level: 1 for region, 0 for segment. The second is a zero next origin or zero page frame (page entry bits 63:12).
- R7: Bit 9 of any entry narrows the permission to read-only. A later level never widens it again.
- R8: A segment entry with bit 8 set ends the walk after two fetches. The address is entry bits 63:20 joined with IO address bits 19:12 and twelve zero bits, and the frame size code is 20.
- R9: A page entry ends the walk with its frame (entry bits 63:12) and size code 12. `res_len_log2` gives log2 of the frame size of the level the walk ended at: 31, 20 or 12.
- R10: Any error forces permission none. `err_pulse` is high for exactly the first cycle of an erroneous result.
- R11: Requests are taken only when idle. A stalled memory read keeps its address, and a stalled result keeps all its fields, until the matching ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Walk request offered |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vpn | input | 30 | IO address bits 41:12 |
| req_origin | input | 64 | Region table origin |
| req_prot | input | 1 | Anchor protection flag |
| mem_valid | output | 1 | Entry read request |
| mem_ready | input | 1 | Memory takes the read |
| mem_addr | output | 64 | Entry byte address |
| rsp_valid | input | 1 | Entry data returned |
| rsp_data | input | 64 | Fetched entry |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result taken |
| res_addr | output | 64 | Translated address |
| res_len_log2 | output | 6 | log2 of frame size |
| res_perm | output | 2 | Permission code |
| res_err | output | 2 | Error code |
| err_pulse | output | 1 | One-cycle error strobe |

## Verification
A read request appears one cycle after its request is taken, or one cycle after the previous entry is consumed. The result appears on the cycle after the response edge that ends the walk. The bench's memory model answers one cycle after each accepted read. It records every fetch address, and these are compared with addresses worked out from the entries. Results are not sampled at a fixed offset. The bench polls `res_valid` at falling edges and checks all fields, including `err_pulse`, on the first cycle it sees it high. It then checks again one cycle later with `res_ready` held low, which confirms the pulse has dropped and the fields are unchanged.

// File: rtl/iova_walk_pkg.sv
`timescale 1ns/1ps
package iova_walk_pkg;
  localparam int ADDR_W     = 64;
  localparam int PAGE_SHIFT = 12;
  localparam int SEG_SHIFT  = 20;
  localparam int REG_SHIFT  = 31;
  localparam int RX_W       = 11;
  localparam int PX_W       = SEG_SHIFT - PAGE_SHIFT;
  localparam int SX_W       = REG_SHIFT - SEG_SHIFT;
  localparam int VPN_W      = PX_W + SX_W + RX_W;
  localparam int ST_ALIGN   = SX_W + 3;
  localparam int PT_ALIGN   = PX_W + 3;
  localparam int LEN_W      = 6;

  localparam int B_PROT   = 9;
  localparam int B_FC     = 8;
  localparam int B_VALID  = 4;
  localparam int B_PVALID = 10;
  localparam logic [1:0] TYPE_REGION  = 2'd1;
  localparam logic [1:0] TYPE_SEGMENT = 2'd0;
  localparam logic [1:0] RLEN_FULL    = 2'd3;

  typedef enum logic [1:0] {LVL_REGION = 2'd0, LVL_SEGMENT = 2'd1, LVL_PAGE = 2'd2} lvl_e;
  typedef enum logic [1:0] {ERR_NONE = 2'd0, ERR_INVAL = 2'd1, ERR_TLEN = 2'd2, ERR_TTYPE = 2'd3} err_e;

  localparam logic [1:0] PERM_NONE = 2'd0;
  localparam logic [1:0] PERM_RO   = 2'd1;
  localparam logic [1:0] PERM_RW   = 2'd3;

  typedef struct packed {
    logic              finish;
    err_e              err;
    logic [1:0]        perm;
    logic [ADDR_W-1:0] next_org;
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  len_log2;
  } verdict_t;
endpackage

// File: rtl/iova_walk_index.sv
`timescale 1ns/1ps
module iova_walk_index
  import iova_walk_pkg::*;
(
  input  lvl_e              lvl,
  input  logic [VPN_W-1:0]  vpn,
  input  logic [ADDR_W-1:0] origin,
  output logic [ADDR_W-1:0] fetch_addr
);
  logic [ADDR_W-1:0] idx;

  always_comb begin
    case (lvl)
      LVL_REGION:  idx = ADDR_W'(vpn[VPN_W-1 -: RX_W]);
      LVL_SEGMENT: idx = ADDR_W'(vpn[PX_W +: SX_W]);
      default:     idx = ADDR_W'(vpn[PX_W-1:0]);
    endcase
    fetch_addr = origin + (idx << 3);
  end
endmodule

// File: rtl/iova_walk_eval.sv
`timescale 1ns/1ps
module iova_walk_eval
  import iova_walk_pkg::*;
(
  input  lvl_e              lvl,
  input  logic [ADDR_W-1:0] entry,
  input  logic [PX_W-1:0]   page_idx,
  input  logic [1:0]        perm_in,
  output verdict_t          verdict
);
  logic              valid_bit;
  logic              type_ok;
  logic              complete;
  logic [ADDR_W-1:0] org;
  logic [ADDR_W-1:0] nto;
  logic [1:0]        perm_n;
  logic [LEN_W-1:0]  len;

  always_comb begin
    case (lvl)
      LVL_REGION: begin
        valid_bit = entry[B_VALID];
        type_ok   = (entry[3:2] == TYPE_REGION);
        org       = {entry[ADDR_W-1:ST_ALIGN], {ST_ALIGN{1'b0}}};
        len       = LEN_W'(REG_SHIFT);
      end
      LVL_SEGMENT: begin
        valid_bit = entry[B_VALID];
        type_ok   = (entry[3:2] == TYPE_SEGMENT);
        org       = {entry[ADDR_W-1:PT_ALIGN], {PT_ALIGN{1'b0}}};
        len       = LEN_W'(SEG_SHIFT);
      end
      default: begin
        valid_bit = entry[B_PVALID];
        type_ok   = 1'b1;
        org       = {entry[ADDR_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
        len       = LEN_W'(PAGE_SHIFT);
      end
    endcase
    nto      = type_ok ? org : '0;
    perm_n   = entry[B_PROT] ? (perm_in & PERM_RO) : perm_in;
    complete = (lvl == LVL_PAGE) || ((lvl == LVL_SEGMENT) && entry[B_FC]);

    verdict.finish   = 1'b1;
    verdict.err      = ERR_NONE;
    verdict.perm     = PERM_NONE;
    verdict.next_org = '0;
    verdict.addr     = '0;
    verdict.len_log2 = len;

    if (entry == '0) begin
      verdict.err = ERR_INVAL;
    end else if (!valid_bit) begin
      verdict.perm = PERM_NONE;
    end else if ((lvl == LVL_REGION) &&
                 ((entry[1:0] != RLEN_FULL) || (entry[7:6] != 2'b00))) begin
      verdict.err = ERR_TLEN;
    end else if (nto == '0) begin
      verdict.err = ERR_TTYPE;
    end else if (complete) begin
      verdict.perm = perm_n;
      if (lvl == LVL_PAGE)
        verdict.addr = org;
      else
        verdict.addr = {entry[ADDR_W-1:SEG_SHIFT], page_idx, {PAGE_SHIFT{1'b0}}};
    end else begin
      verdict.finish   = 1'b0;
      verdict.perm     = perm_n;
      verdict.next_org = nto;
    end
  end
endmodule

// File: rtl/iova_walker.sv
`timescale 1ns/1ps
module iova_walker
  import iova_walk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic [ADDR_W-1:0] req_origin,
  input  logic              req_prot,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              rsp_valid,
  input  logic [ADDR_W-1:0] rsp_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [ADDR_W-1:0] res_addr,
  output logic [LEN_W-1:0]  res_len_log2,
  output logic [1:0]        res_perm,
  output logic [1:0]        res_err,
  output logic              err_pulse
);
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WAIT, S_DONE} st_e;

  st_e               st;
  lvl_e              lvl_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [ADDR_W-1:0] org_q;
  logic [1:0]        perm_q;
  logic [ADDR_W-1:0] fetch_addr;
  verdict_t          verdict;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  err_e              err_q;
  logic              pulse_q;

  iova_walk_index u_index (
    .lvl        (lvl_q),
    .vpn        (vpn_q),
    .origin     (org_q),
    .fetch_addr (fetch_addr)
  );

  iova_walk_eval u_eval (
    .lvl      (lvl_q),
    .entry    (rsp_data),
    .page_idx (vpn_q[PX_W-1:0]),
    .perm_in  (perm_q),
    .verdict  (verdict)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      lvl_q   <= LVL_REGION;
      vpn_q   <= '0;
      org_q   <= '0;
      perm_q  <= PERM_NONE;
      addr_q  <= '0;
      len_q   <= '0;
      err_q   <= ERR_NONE;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            vpn_q  <= req_vpn;
            org_q  <= req_origin;
            perm_q <= req_prot ? PERM_RO : PERM_RW;
            lvl_q  <= LVL_REGION;
            st     <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (mem_ready) st <= S_WAIT;
        end
        S_WAIT: begin
          if (rsp_valid) begin
            perm_q <= verdict.perm;
            if (verdict.finish) begin
              addr_q  <= verdict.addr;
              len_q   <= verdict.len_log2;
              err_q   <= verdict.err;
              pulse_q <= (verdict.err != ERR_NONE);
              st      <= S_DONE;
            end else begin
              org_q <= verdict.next_org;
              lvl_q <= (lvl_q == LVL_REGION) ? LVL_SEGMENT : LVL_PAGE;
              st    <= S_FETCH;
            end
          end
        end
        default: begin
          if (res_ready) st <= S_IDLE;
        end
      endcase
    end
  end

  assign req_ready    = (st == S_IDLE);
  assign mem_valid    = (st == S_FETCH);
  assign mem_addr     = fetch_addr;
  assign res_valid    = (st == S_DONE);
  assign res_addr     = addr_q;
  assign res_len_log2 = len_q;
  assign res_perm     = perm_q;
  assign res_err      = err_q;
  assign err_pulse    = pulse_q;
endmodule

// File: rtl/iova_walker_chk.sv
`timescale 1ns/1ps
module iova_walker_chk
  import iova_walk_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              res_valid,
  input logic              res_ready,
  input logic [ADDR_W-1:0] res_addr,
  input logic [LEN_W-1:0]  res_len_log2,
  input logic [1:0]        res_perm,
  input logic [1:0]        res_err,
  input logic              err_pulse
);
  a_r10_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse);

  a_r10_pulse_with_err: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (res_valid && res_err != 2'd0));

  a_r10_err_no_perm: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_err != 2'd0) |-> (res_perm == PERM_NONE));

  a_r2_perm_code: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_perm != 2'd2));

  a_r9_len_code: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_len_log2 == 6'd12 || res_len_log2 == 6'd20 || res_len_log2 == 6'd31));

  a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));

  a_r11_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_addr) && $stable(res_perm)
                                   && $stable(res_err) && $stable(res_len_log2)));

  a_r11_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_valid && !res_valid));
endmodule

bind iova_walker iova_walker_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .mem_valid    (mem_valid),
  .mem_ready    (mem_ready),
  .mem_addr     (mem_addr),
  .res_valid    (res_valid),
  .res_ready    (res_ready),
  .res_addr     (res_addr),
  .res_len_log2 (res_len_log2),
  .res_perm     (res_perm),
  .res_err      (res_err),
  .err_pulse    (err_pulse)
);

// File: tb/test_iova_walker.sv
`timescale 1ns/1ps
module test_iova_walker;
  typedef struct packed {
    logic [63:0] iova;
    logic [63:0] org;
    logic        aprot;
    logic [63:0] ert;
    logic [63:0] est;
    logic [63:0] ept;
    logic [63:0] eaddr;
    logic [5:0]  elen;
    logic [1:0]  eperm;
    logic [1:0]  eerr;
    logic [1:0]  nf;
  } vec_t;

  localparam int NV = 18;
  localparam logic [63:0] IV = 64'h8020_3123;
  localparam logic [63:0] RT = 64'h10_0017;
  localparam logic [63:0] ST = 64'h20_0010;
  localparam logic [63:0] PT = 64'hABCD_E400;
  localparam vec_t VEC [NV] = '{
    '{IV, 64'h1000, 1'b0, RT, ST, PT, 64'hABCD_E000, 6'd12, 2'd3, 2'd0, 2'd3},
    '{IV, 64'h1000, 1'b1, RT, ST, PT, 64'hABCD_E000, 6'd12, 2'd1, 2'd0, 2'd3},
    '{IV, 64'h1000, 1'b0, RT, 64'h20_0210, PT, 64'hABCD_E000, 6'd12, 2'd1, 2'd0, 2'd3},
    '{IV, 64'h1000, 1'b0, RT, ST, 64'hABCD_E600, 64'hABCD_E000, 6'd12, 2'd1, 2'd0, 2'd3},
    '{IV, 64'h1000, 1'b0, RT, 64'h4560_0110, PT, 64'h4560_3000, 6'd20, 2'd3, 2'd0, 2'd2},
    '{IV, 64'h1000, 1'b0, 64'h0, ST, PT, 64'h0, 6'd31, 2'd0, 2'd1, 2'd1},
    '{IV, 64'h1000, 1'b0, 64'h10_0007, ST, PT, 64'h0, 6'd31, 2'd0, 2'd0, 2'd1},
    '{IV, 64'h1000, 1'b0, 64'h10_0016, ST, PT, 64'h0, 6'd31, 2'd0, 2'd2, 2'd1},
    '{IV, 64'h1000, 1'b0, 64'h10_0057, ST, PT, 64'h0, 6'd31, 2'd0, 2'd2, 2'd1},
    '{IV, 64'h1000, 1'b0, 64'h10_0013, ST, PT, 64'h0, 6'd31, 2'd0, 2'd3, 2'd1},
    '{IV, 64'h1000, 1'b0, RT, 64'h10, PT, 64'h0, 6'd20, 2'd0, 2'd3, 2'd2},
    '{IV, 64'h1000, 1'b0, RT, ST, 64'hABCD_E000, 64'h0, 6'd12, 2'd0, 2'd0, 2'd3},
    '{IV, 64'h1000, 1'b0, RT, ST, 64'h0, 64'h0, 6'd12, 2'd0, 2'd1, 2'd3},
    '{IV, 64'h1000, 1'b0, RT, ST, 64'h400, 64'h0, 6'd12, 2'd0, 2'd3, 2'd3},
    '{IV, 64'h1000, 1'b0, RT, 64'h20_0000, PT, 64'h0, 6'd20, 2'd0, 2'd0, 2'd2},
    '{IV, 64'h1000, 1'b0, RT, 64'h20_0014, PT, 64'h0, 6'd20, 2'd0, 2'd3, 2'd2},
    '{IV, 64'h1000, 1'b0, 64'h10_0217, ST, PT, 64'hABCD_E000, 6'd12, 2'd1, 2'd0, 2'd3},
    '{64'h3FF_800F_F000, 64'h8000, 1'b0, RT, ST, PT, 64'hABCD_E000, 6'd12, 2'd3, 2'd0, 2'd3}
  };
  localparam string VTAG [NV] = '{"R1", "R2", "R7", "R7", "R8", "R3", "R4", "R5", "R5",
                                  "R6", "R6", "R4", "R3", "R6", "R4", "R6", "R7", "R1"};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [29:0] req_vpn = '0;
  logic [63:0] req_origin = '0;
  logic        req_prot = 1'b0;
  logic        mem_valid;
  logic        mem_ready = 1'b1;
  logic [63:0] mem_addr;
  logic        rsp_valid;
  logic [63:0] rsp_data;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [63:0] res_addr;
  logic [5:0]  res_len_log2;
  logic [1:0]  res_perm;
  logic [1:0]  res_err;
  logic        err_pulse;

  logic [63:0] ment [3];
  logic [63:0] faddr [4];
  logic [2:0]  fcnt;
  int          n_chk = 0;
  int          n_fail = 0;
  int          cyc = 0;

  always #2.5 clk = ~clk;

  iova_walker i_iova_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vpn(req_vpn), .req_origin(req_origin), .req_prot(req_prot),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .res_valid(res_valid),
    .res_ready(res_ready), .res_addr(res_addr), .res_len_log2(res_len_log2),
    .res_perm(res_perm), .res_err(res_err), .err_pulse(err_pulse)
  );

  // memory model: one response beat, one cycle after each accepted read
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      fcnt      <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (req_valid && req_ready) fcnt <= '0;
      if (mem_valid && mem_ready) begin
        rsp_valid          <= 1'b1;
        rsp_data           <= (fcnt < 3) ? ment[fcnt[1:0]] : 64'h0;
        faddr[fcnt[1:0]]   <= mem_addr;
        fcnt               <= fcnt + 3'd1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_fetch(input vec_t v, input int k);
    case (k)
      0: exp_fetch = v.org + {42'd0, v.iova[41:31], 3'b0};
      1: exp_fetch = {v.ert[63:14], 14'd0} + {42'd0, v.iova[30:20], 3'b0};
      default: exp_fetch = {v.est[63:11], 11'd0} + {45'd0, v.iova[19:12], 3'b0};
    endcase
  endfunction

  task automatic wait_result(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (res_valid) begin ok = 1'b1; break; end
    end
  endtask

  task automatic run_vec(input vec_t v, input string tag, input bit stall);
    bit ok;
    logic [63:0] a0;
    ment[0] = v.ert; ment[1] = v.est; ment[2] = v.ept;
    @(negedge clk);
    req_vpn = v.iova[41:12]; req_origin = v.org; req_prot = v.aprot; req_valid = 1'b1;
    if (stall) mem_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    if (stall) begin
      a0 = mem_addr;
      for (int s = 0; s < 3; s++) begin
        @(negedge clk);
        check(mem_valid == 1'b1 && mem_addr == a0, "R11 stalled read held", mem_addr, a0);
        check(req_ready == 1'b0, "R11 busy not ready", {63'd0, req_ready}, 64'd0);
      end
      check(a0 == exp_fetch(v, 0), "R1 stalled fetch addr", a0, exp_fetch(v, 0));
      mem_ready = 1'b1;
    end
    wait_result(ok);
    check(ok, {tag, " result timeout"}, {63'd0, ok}, 64'd1);
    if (!ok) return;
    check(fcnt == {1'b0, v.nf}, {tag, " fetch count"}, {61'd0, fcnt}, {62'd0, v.nf});
    for (int k = 0; k < 3; k++)
      if (k < v.nf)
        check(faddr[k] == exp_fetch(v, k), "R1 fetch address", faddr[k], exp_fetch(v, k));
    check(res_addr == v.eaddr, {tag, " addr"}, res_addr, v.eaddr);
    check(res_len_log2 == v.elen, "R9 len", {58'd0, res_len_log2}, {58'd0, v.elen});
    check(res_perm == v.eperm, {tag, " perm"}, {62'd0, res_perm}, {62'd0, v.eperm});
    check(res_err == v.eerr, {tag, " err"}, {62'd0, res_err}, {62'd0, v.eerr});
    check(err_pulse == (v.eerr != 2'd0), "R10 pulse first cycle", {63'd0, err_pulse},
          {63'd0, v.eerr != 2'd0});
    @(negedge clk);
    check(res_valid && res_addr == v.eaddr && res_perm == v.eperm, "R11 result held",
          res_addr, v.eaddr);
    check(err_pulse == 1'b0, "R10 pulse one cycle", {63'd0, err_pulse}, 64'd0);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    check(res_valid == 1'b0 && req_ready == 1'b1, "R11 result released", {63'd0, res_valid}, 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R11 reset ready", {63'd0, req_ready}, 64'd1);
    check(mem_valid == 1'b0 && res_valid == 1'b0, "R11 reset idle", {63'd0, mem_valid}, 64'd0);
    check(err_pulse == 1'b0, "R10 reset pulse", {63'd0, err_pulse}, 64'd0);
    for (int i = 0; i < NV; i++) run_vec(VEC[i], VTAG[i], 1'b0);
    run_vec(VEC[0], "R11", 1'b1);
    run_vec(VEC[7], "R5", 1'b1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule